// File: doc/BRIEF.md
# MAC Address Table Command Engine

A compact forwarding table, searched in parallel, holding up to 32 entries. Each entry is keyed by a 48-bit MAC address together with a 12-bit VLAN ID. Each entry carries a destination field, a 2-bit destination kind, a valid flag, a locked flag and one age bit. A controlling processor places a key, an entry property set and a 3-bit opcode on the inputs and pulses a start strobe. The engine then executes that one operation and lowers `busy` when it has finished. Lookup, indexed read and find-next return their answer on the result outputs, which hold their value until the next such operation.

The table does not learn from traffic. Entries arrive only through learn or indexed write. An ageing sweep removes stale unlocked entries: it runs on command, or periodically from a programmable timer counted in 10 ms units. Find-next walks the table in ascending key order, one operation per step, so software can dump the table without knowing where entries are stored.

Top module: `mac_table_engine`

## Requirements
- R1: `cmd_start` is accepted only while `busy` is 0. All operands are captured on that edge. `busy` is then 1 for exactly one cycle and returns to 0 with the operation complete. A start strobe, or a change of operands, while `busy` is 1 has no effect.
- R2: The opcode values are 0 learn, 1 unlearn, 2 lookup, 3 read at index, 4 write at index, 5 age sweep, 6 find next, 7 clear all. The 60-bit key is {VLAN ID, MAC high, MAC low}. MAC high holds address byte 0 in bits 15:8 and byte 1 in bits 7:0. MAC low holds bytes 2..5 from bit 31 down. Key order compares the VLAN ID first, then MAC high, then MAC low.
- R3: Learn stores the key with the supplied destination, kind and locked flag, sets valid and clears the age bit. If the key is already present, its slot is overwritten. Otherwise the lowest-numbered free slot is used. A key is never held twice.
- R4: Lookup returns the given key. On a hit it returns valid=1 with the stored destination, kind and locked flag. On a miss it returns valid=0 with destination, kind and locked all 0. A hit clears the entry's age bit.
- R5: Unlearn invalidates the entry matching the key. A later lookup of that key misses.
- R6: Write at index stores key, destination, kind, locked and valid (taken from `prop_valid`) into the slot given by `cmd_index`. Read at index returns that slot's key, destination, kind, locked and valid.
- R7: Find next returns the valid entry with the smallest key strictly greater than the given key. When `cmd_skip_locked` is 1, locked entries are passed over. If no entry qualifies, it returns the given key with valid=0 and the other properties 0.
- R8: Clear all invalidates every entry and clears `table_full`.
- R9: A sweep invalidates every valid unlocked entry whose age bit is set, and sets the age bit of every other valid unlocked entry. Locked entries are never changed. With `age_period` nonzero, a sweep runs every `age_period` × `UNIT_CYCLES` cycles. A value of 0 stops the timer.
- R10: Opcode 5 runs one sweep at once. Two sweeps with no intervening hit remove an unlocked entry.
- R11: Learning a new key into a table with no free slot leaves every entry unchanged and sets `table_full`. The flag stays set until a clear all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start strobe for one operation |
| cmd_op | input | 3 | Opcode |
| cmd_skip_locked | input | 1 | Find next passes over locked entries |
| cmd_index | input | IDX_W (5) | Slot for indexed read and write |
| key_mac_hi | input | 16 | MAC bytes 0..1 |
| key_mac_lo | input | 32 | MAC bytes 2..5 |
| key_vid | input | 12 | VLAN ID |
| prop_dest | input | DEST_W (12) | Destination field |
| prop_kind | input | 2 | Destination kind: 0 port, 1 CPU/internal, 2 aggregation group, 3 multicast index |
| prop_valid | input | 1 | Valid flag for write at index |
| prop_locked | input | 1 | Locked flag (entry exempt from ageing) |
| age_period | input | PERIOD_W (16) | Sweep period in timer units; 0 stops the timer |
| busy | output | 1 | Operation in progress |
| res_mac_hi | output | 16 | Result MAC bytes 0..1 |
| res_mac_lo | output | 32 | Result MAC bytes 2..5 |
| res_vid | output | 12 | Result VLAN ID |
| res_dest | output | DEST_W (12) | Result destination |
| res_kind | output | 2 | Result destination kind |
| res_valid | output | 1 | Result hit / entry valid |
| res_locked | output | 1 | Result locked flag |
| table_full | output | 1 | Sticky: a learn found no free slot |

## Verification
The assertions assume software never uses write at index to place a key that is already valid in another slot. The one-hot match check relies on each key being held at most once, and learn is the only path that enforces this. The stimulus keeps to that rule: every indexed write uses a key absent from the table, and each scenario starts from a clear all. The assertions also take the opcode as fixed once captured, which the start-while-busy case probes by changing operands during the busy cycle.

// File: rtl/mact_pkg.sv
// mact_pkg: shared widths, key type and opcode encoding for the MAC table engine.
// Assumes the key is ordered {VLAN ID, MAC high, MAC low}, VLAN most significant.
package mact_pkg;
    localparam int VID_W  = 12;
    localparam int MACH_W = 16;
    localparam int MACL_W = 32;
    localparam int KEY_W  = VID_W + MACH_W + MACL_W;

    typedef logic [KEY_W-1:0] key_t;

    typedef enum logic [2:0] {
        OP_LEARN   = 3'd0,
        OP_UNLEARN = 3'd1,
        OP_LOOKUP  = 3'd2,
        OP_READ    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_SWEEP   = 3'd5,
        OP_NEXT    = 3'd6,
        OP_CLEAR   = 3'd7
    } op_e;
endpackage

// File: rtl/mact_match.sv
// mact_match: parallel exact-match of a probe key against every slot, plus
// lowest free slot. Assumes at most one valid slot holds any key.
module mact_match
    import mact_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  key_t               keys [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    input  key_t               probe,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               has_free,
    output logic [IDX_W-1:0]   free_idx
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = valid[i] && (keys[i] == probe);
    end

    // Priority-encode the matching slot and the lowest empty slot.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!valid[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // R3: learning never leaves two valid copies of a key.
    assert_unique_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/mact_next_sel.sv
// mact_next_sel: picks the valid slot with the smallest key strictly above the
// probe, optionally skipping locked slots. Linear reduction over all slots.
module mact_next_sel
    import mact_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  key_t               keys [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] locked,
    input  key_t               probe,
    input  logic               skip_locked,
    output logic               found,
    output logic [IDX_W-1:0]   sel_idx
);
    logic [ENTRIES-1:0] cand;
    key_t               best;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
        assign cand[i] = valid[i] && (keys[i] > probe) && !(skip_locked && locked[i]);
    end

    // Keep the running minimum among candidate slots.
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        best    = '1;
        for (int i = 0; i < ENTRIES; i++) begin
            if (cand[i] && (!found || keys[i] < best)) begin
                found   = 1'b1;
                sel_idx = IDX_W'(i);
                best    = keys[i];
            end
        end
    end

    // R7: a returned slot is valid and above the probe.
    assert_next_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (valid[sel_idx] && keys[sel_idx] > probe));
endmodule

// File: rtl/mact_age_timer.sv
// mact_age_timer: emits a one-cycle sweep request every period x UNIT_CYCLES
// cycles. A zero period holds the counters at zero.
module mact_age_timer #(
    parameter int UNIT_CYCLES = 1_000_000,
    parameter int PERIOD_W    = 16,
    localparam int UNIT_W = $clog2(UNIT_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    output logic                sweep_req
);
    logic [UNIT_W-1:0]   unit_cnt;
    logic [PERIOD_W-1:0] per_cnt;

    // Count base units, then periods, and pulse at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n || period == '0) begin
            unit_cnt  <= '0;
            per_cnt   <= '0;
            sweep_req <= 1'b0;
        end else begin
            sweep_req <= 1'b0;
            if (unit_cnt == UNIT_W'(UNIT_CYCLES - 1)) begin
                unit_cnt <= '0;
                if (per_cnt == period - 1'b1) begin
                    per_cnt   <= '0;
                    sweep_req <= 1'b1;
                end else begin
                    per_cnt <= per_cnt + 1'b1;
                end
            end else begin
                unit_cnt <= unit_cnt + 1'b1;
            end
        end
    end

    // R9: sweep requests are single-cycle pulses.
    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_req |=> !sweep_req);
endmodule

// File: rtl/mac_table_engine.sv
// mac_table_engine: command engine over a parallel-searched MAC/VLAN table.
// Captures one operation on an accepted start and executes it in the single
// busy cycle that follows. Timer sweeps run only in idle cycles.
// Assumes software keeps keys unique when using write at index.
module mac_table_engine
    import mact_pkg::*;
#(
    parameter int ENTRIES     = 32,
    parameter int DEST_W      = 12,
    parameter int PERIOD_W    = 16,
    parameter int UNIT_CYCLES = 1_000_000,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [2:0]          cmd_op,
    input  logic                cmd_skip_locked,
    input  logic [IDX_W-1:0]    cmd_index,
    input  logic [15:0]         key_mac_hi,
    input  logic [31:0]         key_mac_lo,
    input  logic [11:0]         key_vid,
    input  logic [DEST_W-1:0]   prop_dest,
    input  logic [1:0]          prop_kind,
    input  logic                prop_valid,
    input  logic                prop_locked,
    input  logic [PERIOD_W-1:0] age_period,
    output logic                busy,
    output logic [15:0]         res_mac_hi,
    output logic [31:0]         res_mac_lo,
    output logic [11:0]         res_vid,
    output logic [DEST_W-1:0]   res_dest,
    output logic [1:0]          res_kind,
    output logic                res_valid,
    output logic                res_locked,
    output logic                table_full
);
    // Captured operation.
    logic               busy_q;
    op_e                op_q;
    key_t               key_q;
    logic [DEST_W-1:0]  dest_q;
    logic [1:0]         kind_q;
    logic               pv_q, pl_q, skip_q;
    logic [IDX_W-1:0]   idx_q;

    // Table storage.
    key_t               key_r  [ENTRIES];
    logic [DEST_W-1:0]  dest_r [ENTRIES];
    logic [1:0]         kind_r [ENTRIES];
    logic [ENTRIES-1:0] valid_r, lock_r, age_r;
    logic               full_q;

    // Result registers.
    key_t               res_key;

    logic               accept, hit, has_free, nx_found, sweep_req, sweep_pend, do_sweep;
    logic [IDX_W-1:0]   hit_idx, free_idx, nx_idx, wr_idx;
    logic               wr_en;

    assign accept   = cmd_start && !busy_q;
    assign do_sweep = busy_q ? (op_q == OP_SWEEP) : sweep_pend;

    mact_match #(.ENTRIES(ENTRIES)) u_match (
        .clk(clk), .rst_n(rst_n), .keys(key_r), .valid(valid_r), .probe(key_q),
        .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
    );

    mact_next_sel #(.ENTRIES(ENTRIES)) u_next (
        .clk(clk), .rst_n(rst_n), .keys(key_r), .valid(valid_r), .locked(lock_r),
        .probe(key_q), .skip_locked(skip_q), .found(nx_found), .sel_idx(nx_idx)
    );

    mact_age_timer #(.UNIT_CYCLES(UNIT_CYCLES), .PERIOD_W(PERIOD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .period(age_period), .sweep_req(sweep_req)
    );

    // Busy flag and sweep-request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            sweep_pend <= 1'b0;
        end else begin
            busy_q     <= accept;
            sweep_pend <= (sweep_pend && busy_q) || sweep_req;
        end
    end

    // Capture operands when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_LOOKUP;
            key_q  <= '0;
            dest_q <= '0;
            kind_q <= '0;
            pv_q   <= 1'b0;
            pl_q   <= 1'b0;
            skip_q <= 1'b0;
            idx_q  <= '0;
        end else if (accept) begin
            op_q   <= op_e'(cmd_op);
            key_q  <= {key_vid, key_mac_hi, key_mac_lo};
            dest_q <= prop_dest;
            kind_q <= prop_kind;
            pv_q   <= prop_valid;
            pl_q   <= prop_locked;
            skip_q <= cmd_skip_locked;
            idx_q  <= cmd_index;
        end
    end

    // Choose the slot a learn or indexed write stores into.
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = idx_q;
        if (busy_q && op_q == OP_LEARN) begin
            wr_en  = hit || has_free;
            wr_idx = hit ? hit_idx : free_idx;
        end else if (busy_q && op_q == OP_WRITE) begin
            wr_en  = 1'b1;
        end
    end

    // Entry payload storage (no reset; qualified by the valid flags).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_r[wr_idx]  <= key_q;
            dest_r[wr_idx] <= dest_q;
            kind_r[wr_idx] <= kind_q;
        end
    end

    // Per-entry flags, sweep and full status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_r <= '0;
            lock_r  <= '0;
            age_r   <= '0;
            full_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                valid_r[wr_idx] <= (op_q == OP_WRITE) ? pv_q : 1'b1;
                lock_r[wr_idx]  <= pl_q;
                age_r[wr_idx]   <= 1'b0;
            end
            if (busy_q) begin
                case (op_q)
                    OP_LEARN:   if (!hit && !has_free) full_q <= 1'b1;
                    OP_UNLEARN: if (hit) valid_r[hit_idx] <= 1'b0;
                    OP_LOOKUP:  if (hit) age_r[hit_idx] <= 1'b0;
                    OP_CLEAR: begin
                        valid_r <= '0;
                        age_r   <= '0;
                        full_q  <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (do_sweep) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (valid_r[i] && !lock_r[i]) begin
                        if (age_r[i]) begin
                            valid_r[i] <= 1'b0;
                            age_r[i]   <= 1'b0;
                        end else begin
                            age_r[i]   <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Load the result registers for lookup, read and find-next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_key    <= '0;
            res_dest   <= '0;
            res_kind   <= '0;
            res_valid  <= 1'b0;
            res_locked <= 1'b0;
        end else if (busy_q) begin
            case (op_q)
                OP_LOOKUP: begin
                    res_key    <= key_q;
                    res_dest   <= hit ? dest_r[hit_idx] : '0;
                    res_kind   <= hit ? kind_r[hit_idx] : '0;
                    res_valid  <= hit;
                    res_locked <= hit && lock_r[hit_idx];
                end
                OP_READ: begin
                    res_key    <= key_r[idx_q];
                    res_dest   <= dest_r[idx_q];
                    res_kind   <= kind_r[idx_q];
                    res_valid  <= valid_r[idx_q];
                    res_locked <= lock_r[idx_q];
                end
                OP_NEXT: begin
                    res_key    <= nx_found ? key_r[nx_idx] : key_q;
                    res_dest   <= nx_found ? dest_r[nx_idx] : '0;
                    res_kind   <= nx_found ? kind_r[nx_idx] : '0;
                    res_valid  <= nx_found;
                    res_locked <= nx_found && lock_r[nx_idx];
                end
                default: ;
            endcase
        end
    end

    assign busy       = busy_q;
    assign table_full = full_q;
    assign res_vid    = res_key[KEY_W-1 -: VID_W];
    assign res_mac_hi = res_key[MACL_W +: MACH_W];
    assign res_mac_lo = res_key[MACL_W-1:0];

    // R1: execution takes exactly one busy cycle.
    assert_busy_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q);
    // R1: an idle start is always taken.
    assert_start_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy_q) |=> busy_q);
    // R9: a sweep never alters locked valid entries.
    assert_locked_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (do_sweep && !wr_en) |=> ((valid_r & lock_r) == $past(valid_r & lock_r)));
    // R8: clear all leaves no valid entry.
    assert_clear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && op_q == OP_CLEAR) |=> (valid_r == '0));
    // R11: the full flag is sticky until clear all.
    assert_full_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !(busy_q && op_q == OP_CLEAR)) |=> full_q);
endmodule

// File: tb/mac_table_engine_bench.sv
module mac_table_engine_bench;
    localparam int N = 32;

    typedef struct {
        bit          chk;
        bit          vonly;
        logic [59:0] key;
        logic [11:0] dest;
        logic [1:0]  kind;
        logic        vld;
        logic        lck;
        string       tag;
    } exp_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_start = 1'b0, cmd_skip_locked = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [4:0]  cmd_index = '0;
    logic [15:0] key_mac_hi = '0;
    logic [31:0] key_mac_lo = '0;
    logic [11:0] key_vid = '0, prop_dest = '0;
    logic [1:0]  prop_kind = '0;
    logic        prop_valid = 1'b0, prop_locked = 1'b0;
    logic [15:0] age_period = '0;
    logic        busy, res_valid, res_locked, table_full;
    logic [15:0] res_mac_hi;
    logic [31:0] res_mac_lo;
    logic [11:0] res_vid, res_dest;
    logic [1:0]  res_kind;

    int   nchk = 0, nfail = 0;
    bit   done = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    mac_table_engine #(.ENTRIES(N), .UNIT_CYCLES(10)) u_mac_table_engine (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_skip_locked(cmd_skip_locked), .cmd_index(cmd_index),
        .key_mac_hi(key_mac_hi), .key_mac_lo(key_mac_lo), .key_vid(key_vid),
        .prop_dest(prop_dest), .prop_kind(prop_kind), .prop_valid(prop_valid),
        .prop_locked(prop_locked), .age_period(age_period), .busy(busy),
        .res_mac_hi(res_mac_hi), .res_mac_lo(res_mac_lo), .res_vid(res_vid),
        .res_dest(res_dest), .res_kind(res_kind), .res_valid(res_valid),
        .res_locked(res_locked), .table_full(table_full)
    );

    task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [59:0] K(input logic [11:0] v, input logic [15:0] h, input logic [31:0] l);
        return {v, h, l};
    endfunction

    function automatic exp_t none();
        exp_t e;
        e.chk = 0; e.vonly = 0; e.key = '0; e.dest = '0; e.kind = '0; e.vld = 0; e.lck = 0; e.tag = "";
        return e;
    endfunction

    function automatic exp_t ex(input logic [59:0] k, input logic [11:0] d, input logic [1:0] kd,
                                input logic v, input logic l, input string tag);
        exp_t e;
        e.chk = 1; e.vonly = 0; e.key = k; e.dest = d; e.kind = kd; e.vld = v; e.lck = l; e.tag = tag;
        return e;
    endfunction

    // Monitor: pop one expected item per completed operation and compare.
    always @(negedge clk) begin : monitor
        static logic prev_busy = 1'b0;
        if (rst_n && prev_busy && !busy) begin
            if (sb.size() == 0) begin
                check(0, "R1 unexpected completion", 80'(busy), 80'(0));
            end else begin
                exp_t e;
                logic [79:0] a, x;
                e = sb.pop_front();
                if (e.chk) begin
                    a = {4'h0, res_vid, res_mac_hi, res_mac_lo, res_dest, res_kind, res_valid, res_locked};
                    x = {4'h0, e.key, e.dest, e.kind, e.vld, e.lck};
                    if (e.vonly) check(res_valid == e.vld, e.tag, 80'(res_valid), 80'(e.vld));
                    else         check(a == x, e.tag, a, x);
                end
            end
        end
        prev_busy = busy;
    end

    // Driver: push expectation, strobe one operation, wait for completion.
    task automatic issue(input logic [2:0] op, input logic [59:0] k, input logic [11:0] d,
                         input logic [1:0] kd, input logic pv, input logic pl,
                         input int idx, input logic skip, input exp_t e);
        sb.push_back(e);
        @(negedge clk);
        cmd_op = op; {key_vid, key_mac_hi, key_mac_lo} = k; prop_dest = d; prop_kind = kd;
        prop_valid = pv; prop_locked = pl; cmd_index = 5'(idx); cmd_skip_locked = skip;
        cmd_start = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R1 busy raised", 80'(busy), 80'(1));
        cmd_start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy cleared", 80'(busy), 80'(0));
    endtask

    task automatic learn(input logic [59:0] k, input logic [11:0] d, input logic [1:0] kd, input logic l);
        issue(3'd0, k, d, kd, 1'b1, l, 0, 1'b0, none());
    endtask
    task automatic lookup(input logic [59:0] k, input exp_t e);
        issue(3'd2, k, '0, '0, 1'b0, 1'b0, 0, 1'b0, e);
    endtask
    task automatic simple(input logic [2:0] op, input logic [59:0] k);
        issue(op, k, '0, '0, 1'b0, 1'b0, 0, 1'b0, none());
    endtask
    task automatic nxt(input logic [59:0] k, input logic skip, input exp_t e);
        issue(3'd6, k, '0, '0, 1'b0, 1'b0, 0, skip, e);
    endtask
    task automatic rd(input int idx, input exp_t e);
        issue(3'd3, '0, '0, '0, 1'b0, 1'b0, idx, 1'b0, e);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            report();
        end
    end

    initial begin : stim
        logic [59:0] k1, k2, k3, k4, ka, kb, kc, kd, kj, ke, kf, kg, kh, ki, kx;
        exp_t e;
        k1 = K(12'd1, 16'h0011, 32'h22334455); k2 = K(12'd1, 16'h0011, 32'h22334456);
        k3 = K(12'd3, 16'hA000, 32'h0000_0001); k4 = K(12'd4, 16'h0000, 32'h0000_0004);
        ka = K(12'd1, 16'h0, 32'h10); kb = K(12'd1, 16'h0, 32'h20);
        kc = K(12'd2, 16'h0, 32'h05); kd = K(12'd1, 16'h0, 32'h08);
        kj = K(12'd1, 16'h1, 32'h00);
        ke = K(12'd7, 16'h7, 32'h7); kf = K(12'd8, 16'h8, 32'h8); kg = K(12'd9, 16'h9, 32'h9);
        kh = K(12'd5, 16'h5, 32'h5); ki = K(12'd6, 16'h6, 32'h6);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R11)
        check(busy == 0, "R1 reset busy", 80'(busy), 80'(0));
        check(table_full == 0, "R11 reset full", 80'(table_full), 80'(0));
        check(res_valid == 0, "R4 reset res_valid", 80'(res_valid), 80'(0));

        // R3/R4: learn, hit, miss, slot choice, overwrite
        learn(k1, 12'd7, 2'd0, 1'b0);
        lookup(k1, ex(k1, 12'd7, 2'd0, 1, 0, "R4 lookup hit"));
        lookup(k2, ex(k2, 12'd0, 2'd0, 0, 0, "R4 lookup miss"));
        rd(0, ex(k1, 12'd7, 2'd0, 1, 0, "R3 lowest free slot"));
        learn(k1, 12'd9, 2'd3, 1'b1);
        lookup(k1, ex(k1, 12'd9, 2'd3, 1, 1, "R3 overwrite existing"));
        e = ex('0, '0, '0, 0, 0, "R3 no duplicate slot"); e.vonly = 1;
        rd(1, e);

        // R5: unlearn
        simple(3'd1, k1);
        lookup(k1, ex(k1, 12'd0, 2'd0, 0, 0, "R5 unlearn removes"));

        // R6: indexed write and read
        issue(3'd4, k3, 12'd5, 2'd2, 1'b1, 1'b0, 4, 1'b0, none());
        rd(4, ex(k3, 12'd5, 2'd2, 1, 0, "R6 read after write"));
        lookup(k3, ex(k3, 12'd5, 2'd2, 1, 0, "R6 written entry found"));

        // R1: start held into busy cycle with new operands is ignored
        sb.push_back(ex(k3, 12'd5, 2'd2, 1, 0, "R1 first operation kept"));
        @(negedge clk);
        cmd_op = 3'd2; {key_vid, key_mac_hi, key_mac_lo} = k3; cmd_start = 1'b1;
        @(negedge clk);
        cmd_op = 3'd0; {key_vid, key_mac_hi, key_mac_lo} = k4; prop_dest = 12'd1;
        @(negedge clk);
        cmd_start = 1'b0;
        check(busy == 0, "R1 no second accept", 80'(busy), 80'(0));
        lookup(k4, ex(k4, 12'd0, 2'd0, 0, 0, "R1 start while busy ignored"));

        // R8: clear all
        simple(3'd7, '0);
        lookup(k3, ex(k3, 12'd0, 2'd0, 0, 0, "R8 clear removes entry"));
        e = ex('0, '0, '0, 0, 0, "R8 slot invalid after clear"); e.vonly = 1;
        rd(4, e);

        // R7/R2: ordered find-next
        learn(ka, 12'd1, 2'd0, 1'b0);
        learn(kb, 12'd2, 2'd1, 1'b1);
        learn(kc, 12'd3, 2'd2, 1'b0);
        learn(kd, 12'd4, 2'd3, 1'b0);
        learn(kj, 12'd6, 2'd0, 1'b0);
        nxt('0, 1'b0, ex(kd, 12'd4, 2'd3, 1, 0, "R7 smallest from zero"));
        nxt(kd, 1'b0, ex(ka, 12'd1, 2'd0, 1, 0, "R7 strictly greater"));
        nxt(ka, 1'b0, ex(kb, 12'd2, 2'd1, 1, 1, "R7 locked returned"));
        nxt(ka, 1'b1, ex(kj, 12'd6, 2'd0, 1, 0, "R7 locked skipped"));
        nxt(kb, 1'b0, ex(kj, 12'd6, 2'd0, 1, 0, "R2 MAC high above MAC low"));
        nxt(kj, 1'b0, ex(kc, 12'd3, 2'd2, 1, 0, "R2 VLAN most significant"));
        nxt(kc, 1'b0, ex(kc, 12'd0, 2'd0, 0, 0, "R7 none above"));

        // R10/R9: commanded sweeps
        simple(3'd7, '0);
        learn(ke, 12'd1, 2'd0, 1'b0);
        simple(3'd5, '0);
        simple(3'd5, '0);
        lookup(ke, ex(ke, 12'd0, 2'd0, 0, 0, "R10 two sweeps remove"));
        learn(kf, 12'd2, 2'd0, 1'b0);
        learn(kg, 12'd3, 2'd1, 1'b1);
        simple(3'd5, '0);
        lookup(kf, ex(kf, 12'd2, 2'd0, 1, 0, "R10 one sweep keeps"));
        simple(3'd5, '0);
        lookup(kf, ex(kf, 12'd2, 2'd0, 1, 0, "R9 hit clears age"));
        simple(3'd5, '0);
        simple(3'd5, '0);
        lookup(kg, ex(kg, 12'd3, 2'd1, 1, 1, "R9 locked never aged"));

        // R9: periodic sweeps from the timer
        simple(3'd7, '0);
        learn(kh, 12'd4, 2'd0, 1'b0);
        learn(ki, 12'd5, 2'd0, 1'b1);
        @(negedge clk);
        age_period = 16'd2;
        repeat (90) @(negedge clk);
        age_period = 16'd0;
        lookup(kh, ex(kh, 12'd0, 2'd0, 0, 0, "R9 timer ages out"));
        lookup(ki, ex(ki, 12'd5, 2'd0, 1, 1, "R9 timer spares locked"));

        // R11: full table
        simple(3'd7, '0);
        for (int i = 0; i < N; i++) learn(K(12'd2, 16'h0, 32'(100 + i)), 12'(i), 2'd0, 1'b1);
        check(table_full == 0, "R11 not full at capacity", 80'(table_full), 80'(0));
        kx = K(12'd2, 16'h0, 32'd999);
        learn(kx, 12'd1, 2'd0, 1'b0);
        check(table_full == 1, "R11 full flag set", 80'(table_full), 80'(1));
        lookup(kx, ex(kx, 12'd0, 2'd0, 0, 0, "R11 overflow key not stored"));
        rd(31, ex(K(12'd2, 16'h0, 32'd131), 12'd31, 2'd0, 1, 1, "R11 last slot unchanged"));
        simple(3'd7, '0);
        check(table_full == 0, "R8 clear drops full", 80'(table_full), 80'(0));

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1 all operations completed", 80'(sb.size()), 80'(0));
        done = 1;
        report();
    end
endmodule